// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits next to the command decoder of a synchronous DRAM-style memory. It turns a burst request into the sequence of column addresses the array is accessed with, one address per clock. A request carries a starting column, a burst length, an ordering (linear or interleaved), a CAS latency, a read/write flag and an auto-precharge request. The block presents one column per cycle with a valid flag. For reads it also produces a data-valid strobe, delayed by the programmed CAS latency. When auto precharge was requested and the burst runs to its natural end, it raises a one-cycle precharge request.

A full-page burst walks the whole row and wraps from the last column back to column 0. It only ends when it is stopped. A stop strobe cuts any burst short. A new start strobe during a running burst abandons the old burst and begins the new one in the same edge.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low, and after reset until the first start, col_valid_o, rd_valid_o and auto_pre_o are 0.
- R2: On the clock edge that samples start_i high, the block captures the request. In the following cycle col_valid_o is 1 and col_o equals start_col_i.
- R3: bl_code_i values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. col_valid_o stays high for exactly that many consecutive cycles and then drops.
- R4: With interleave_i = 0 and a length L of 2, 4 or 8, beat i presents the start column with its low log2(L) bits replaced by (low bits + i) mod L. The burst therefore wraps inside the L-aligned block.
- R5: With interleave_i = 1 and a length L of 2, 4 or 8, beat i presents the start column with its low log2(L) bits XORed with i.
- R6: bl_code_i values 4 to 7 select a full-page burst. Beat i presents (start_col_i + i) mod 256 whatever interleave_i is, and the burst continues until it is stopped or restarted.
- R7: A stop_i sampled high at an edge, without start_i, ends the burst: col_valid_o is 0 in the following cycle. A stop_i while idle has no effect.
- R8: For a read (is_read_i = 1), rd_valid_o repeats the col_valid_o pattern delayed by the latched CAS latency. cas_lat_i values 1, 2 and 3 give 1, 2 and 3 cycles, and value 0 behaves as 1. A write burst never raises rd_valid_o.
- R9: If auto_pre_i was 1 at the start, auto_pre_o pulses high for one cycle in the cycle right after the final beat of a burst that ends naturally. A stopped, restarted or full-page burst produces no pulse.
- R10: A start_i during an active burst ends the old burst without a precharge pulse. The new burst's first column appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the request fields below |
| start_col_i | input | 8 | First column of the burst |
| bl_code_i | input | 3 | Burst length code: 0..3 give 1/2/4/8 beats, 4..7 give full page |
| interleave_i | input | 1 | 1 selects interleaved ordering, 0 linear |
| cas_lat_i | input | 2 | Read latency in cycles (0 treated as 1) |
| is_read_i | input | 1 | 1 for a read burst, 0 for a write burst |
| auto_pre_i | input | 1 | Request a precharge when the burst ends |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Current column address |
| col_valid_o | output | 1 | col_o holds a beat of the burst |
| rd_valid_o | output | 1 | Read data valid, CAS-latency delayed |
| auto_pre_o | output | 1 | One-cycle auto precharge request |

## Verification
A wrong beat counter or captured base address shows up as a wrong col_o on the very next beat. A wrong length mask shows as col_valid_o dropping one or more cycles early or late, and as a precharge pulse in the wrong cycle, at most eight cycles after the start. A wrong latency tap or delay stage shifts rd_valid_o by whole cycles against the column beats, and this is visible within three cycles of the first beat. Faults in the full-page wrap appear only once the counter crosses column 255. The bench therefore runs a page burst past that boundary before stopping it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned COL_W_DEF  = 8;
  localparam int unsigned CL_MAX_DEF = 3;
  localparam int unsigned BLC_W      = 3;

  typedef enum logic [BLC_W-1:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd4
  } blc_e;
endpackage

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic             ilv_i,
  input  logic             page_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] hi;

  assign sum = base_i + beat_i;
  assign hi  = base_i & ~mask_i;

  always_comb begin
    if (page_i)     col_o = sum;
    else if (ilv_i) col_o = hi | ((base_i ^ beat_i) & mask_i);
    else            col_o = hi | (sum & mask_i);
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned CL_MAX = 3,
  parameter int unsigned CL_W   = $clog2(CL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [BLC_W-1:0] bl_code_i,
  input  logic             interleave_i,
  input  logic [CL_W-1:0]  cas_lat_i,
  input  logic             is_read_i,
  input  logic             auto_pre_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] beat_o,
  output logic             ilv_o,
  output logic             page_o,
  output logic             rd_o,
  output logic [CL_W-1:0]  cl_o,
  output logic             auto_pre_o
);
  logic             ap_q;
  logic             last;
  logic [COL_W-1:0] new_mask;
  logic [CL_W-1:0]  new_cl;

  always_comb begin
    if (bl_code_i[BLC_W-1]) new_mask = '1;
    else new_mask = COL_W'((COL_W'(1) << bl_code_i[1:0]) - COL_W'(1));
  end

  always_comb begin
    if (cas_lat_i == '0)                   new_cl = CL_W'(1);
    else if (cas_lat_i > CL_W'(CL_MAX))    new_cl = CL_W'(CL_MAX);
    else                                   new_cl = cas_lat_i;
  end

  assign last = !page_o && (beat_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      base_o     <= '0;
      mask_o     <= '0;
      beat_o     <= '0;
      ilv_o      <= 1'b0;
      page_o     <= 1'b0;
      rd_o       <= 1'b0;
      ap_q       <= 1'b0;
      cl_o       <= CL_W'(1);
      auto_pre_o <= 1'b0;
    end else begin
      auto_pre_o <= active_o && !start_i && !stop_i && last && ap_q;
      if (start_i) begin
        active_o <= 1'b1;
        base_o   <= start_col_i;
        mask_o   <= new_mask;
        beat_o   <= '0;
        ilv_o    <= interleave_i;
        page_o   <= bl_code_i[BLC_W-1];
        rd_o     <= is_read_i;
        ap_q     <= auto_pre_i;
        cl_o     <= new_cl;
      end else if (active_o) begin
        if (stop_i || last) active_o <= 1'b0;
        else                beat_o   <= beat_o + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/bcs_lat_pipe.sv
module bcs_lat_pipe #(
  parameter int unsigned CL_MAX = 3,
  parameter int unsigned CL_W   = $clog2(CL_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [CL_W-1:0] cl_i,
  output logic            vld_o
);
  logic [CL_MAX-1:0] stage;

  for (genvar g = 0; g < CL_MAX; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage[g] <= 1'b0;
      else if (g == 0) stage[g] <= vld_i;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  always_comb begin
    vld_o = 1'b0;
    for (int i = 0; i < CL_MAX; i++)
      if (cl_i == CL_W'(i + 1)) vld_o = stage[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W  = COL_W_DEF,
  parameter int unsigned CL_MAX = CL_MAX_DEF,
  parameter int unsigned CL_W   = $clog2(CL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [BLC_W-1:0] bl_code_i,
  input  logic             interleave_i,
  input  logic [CL_W-1:0]  cas_lat_i,
  input  logic             is_read_i,
  input  logic             auto_pre_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_valid_o,
  output logic             rd_valid_o,
  output logic             auto_pre_o
);
  logic             active;
  logic [COL_W-1:0] base, mask, beat;
  logic             ilv, page, rd;
  logic [CL_W-1:0]  cl;

  bcs_beat_ctrl #(.COL_W(COL_W), .CL_MAX(CL_MAX), .CL_W(CL_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .bl_code_i    (bl_code_i),
    .interleave_i (interleave_i),
    .cas_lat_i    (cas_lat_i),
    .is_read_i    (is_read_i),
    .auto_pre_i   (auto_pre_i),
    .stop_i       (stop_i),
    .active_o     (active),
    .base_o       (base),
    .mask_o       (mask),
    .beat_o       (beat),
    .ilv_o        (ilv),
    .page_o       (page),
    .rd_o         (rd),
    .cl_o         (cl),
    .auto_pre_o   (auto_pre_o)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .mask_i (mask),
    .beat_i (beat),
    .ilv_i  (ilv),
    .page_i (page),
    .col_o  (col_o)
  );

  bcs_lat_pipe #(.CL_MAX(CL_MAX), .CL_W(CL_W)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (active && rd),
    .cl_i   (cl),
    .vld_o  (rd_valid_o)
  );

  assign col_valid_o = active;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned CL_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic             rd_valid_o,
  input logic             auto_pre_o
);
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_valid_o && col_o == $past(start_col_i))); // R2

  AST_SINGLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && bl_code_i == 3'd0) |-> ##2 (!col_valid_o || $past(start_i))); // R3

  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !col_valid_o); // R7

  AST_RD_HAS_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(col_valid_o) || $past(col_valid_o, 2) || $past(col_valid_o, 3))); // R8

  AST_AP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |=> !auto_pre_o); // R9

  AST_AP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |-> (!col_valid_o && $past(col_valid_o))); // R9
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .CL_W(CL_W)) u_bcs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl_code_i   (bl_code_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .col_valid_o (col_valid_o),
  .rd_valid_o  (rd_valid_o),
  .auto_pre_o  (auto_pre_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, ilv = 1'b0, rd = 1'b0, ap = 1'b0, stop = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] blc = '0;
  logic [1:0] cl = 2'd1;
  logic [7:0] col;
  logic       cvld, rvld, apo;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .bl_code_i(blc), .interleave_i(ilv), .cas_lat_i(cl), .is_read_i(rd),
    .auto_pre_i(ap), .stop_i(stop), .col_o(col), .col_valid_o(cvld),
    .rd_valid_o(rvld), .auto_pre_o(apo)
  );

  typedef struct packed {
    logic [2:0]  bl;
    logic        il;
    logic [7:0]  sc;
    logic [3:0]  n;
    logic [63:0] seq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 1'b0, 8'h35, 4'd8, 64'h35363730_31323334}, // R4
    '{3'd3, 1'b1, 8'h35, 4'd8, 64'h35343736_31303332}, // R5
    '{3'd2, 1'b0, 8'h0D, 4'd4, 64'h0D0E0F0C_00000000}, // R4
    '{3'd2, 1'b1, 8'h0D, 4'd4, 64'h0D0C0F0E_00000000}, // R5
    '{3'd1, 1'b1, 8'hA1, 4'd2, 64'hA1A00000_00000000}, // R5
    '{3'd1, 1'b0, 8'hA1, 4'd2, 64'hA1A00000_00000000}, // R4
    '{3'd0, 1'b0, 8'h7F, 4'd1, 64'h7F000000_00000000}, // R3
    '{3'd3, 1'b0, 8'hF8, 4'd8, 64'hF8F9FAFB_FCFDFEFF}  // R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go(input logic [2:0] b, input logic i, input logic [7:0] c,
                    input logic [1:0] l, input logic r, input logic a);
    blc = b; ilv = i; scol = c; cl = l; rd = r; ap = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cvld && !rvld && !apo, "R1 in reset", {cvld, rvld, apo}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cvld && !rvld && !apo, "R1 after reset", {cvld, rvld, apo}, 0);

    // table walk: reads with auto precharge, latency 1..3
    for (int v = 0; v < NV; v++) begin
      int n, lat;
      n   = int'(VECS[v].n);
      lat = (v % 3) + 1;
      go(VECS[v].bl, VECS[v].il, VECS[v].sc, 2'(lat), 1'b1, 1'b1);
      for (int k = 0; k < n + lat + 1; k++) begin
        if (k < n) begin
          logic [7:0] e;
          e = VECS[v].seq[63 - 8*k -: 8];
          chk(cvld && col == e, "R2/R3/R4/R5 column", {cvld, col}, {1'b1, e});
        end else
          chk(!cvld, "R3 burst end", cvld, 0);
        chk(rvld == (k >= lat && k < n + lat), "R8 read valid", rvld, (k >= lat && k < n + lat));
        chk(apo == (k == n), "R9 precharge pulse", apo, (k == n));
        @(negedge clk);
      end
    end

    // full page, interleave ignored, write: wrap 255->0, no rd_valid
    go(3'd5, 1'b1, 8'hFE, 2'd1, 1'b0, 1'b1);
    for (int k = 0; k < 260; k++) begin
      chk(cvld && col == 8'(8'hFE + k), "R6 page column", col, 8'(8'hFE + k));
      chk(!rvld, "R8 write has no read valid", rvld, 0);
      chk(!apo, "R9 no pulse in page burst", apo, 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!cvld, "R7 stop ends page burst", cvld, 0);
    chk(!apo, "R9 no pulse after stop", apo, 0);
    @(negedge clk);
    chk(!apo && !cvld, "R9 stays quiet", {apo, cvld}, 0);

    // stop while idle
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!cvld && !apo, "R7 idle stop ignored", {cvld, apo}, 0);

    // stop mid 8-beat burst with precharge requested
    go(3'd3, 1'b0, 8'h20, 2'd2, 1'b1, 1'b1);
    chk(col == 8'h20, "R2 first column", col, 8'h20);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!cvld, "R7 stop mid burst", cvld, 0);
    for (int k = 0; k < 10; k++) begin
      chk(!apo, "R9 no pulse after stop", apo, 0);
      @(negedge clk);
    end

    // abort by new start
    go(3'd3, 1'b0, 8'h10, 2'd1, 1'b0, 1'b1);
    chk(col == 8'h10, "R10 old beat 0", col, 8'h10);
    blc = 3'd0; scol = 8'h40; ap = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cvld && col == 8'h40, "R10 new burst first column", col, 8'h40);
    chk(!apo, "R10 no pulse on abort", apo, 0);
    @(negedge clk);
    chk(!cvld, "R10 new single beat ends", cvld, 0);
    chk(apo, "R9 pulse after new burst", apo, 1);

    // latency code 0 behaves as 1
    go(3'd0, 1'b0, 8'h55, 2'd0, 1'b1, 1'b0);
    chk(cvld && !rvld, "R8 cl0 beat", {cvld, rvld}, 2);
    @(negedge clk);
    chk(rvld, "R8 cl0 acts as cl1", rvld, 1);
    @(negedge clk);
    chk(!rvld && !apo, "R8 cl0 done", {rvld, apo}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule